// File: doc/BRIEF.md
# Packed-Shift Encoding Exception Prioritizer

This block sits in a decode stage and screens the three immediate-form packed-shift opcodes (second byte 71h, 72h and 73h behind the two-byte escape). For each instruction presented with a valid strobe it produces one registered exception code. Encodings whose ModR/M byte falls outside the legal set raise invalid opcode. Legal encodings raise device-not-available when the task-switched control bit is set. Invalid opcode wins over device-not-available, so a program that runs into an illegal shift form gets the correct fault whatever the task-switched state is.

Every other instruction, including anything not behind the escape byte, leaves with code "none". The result appears one clock after the strobe. A flush input drops whatever the output register would hold. The block keeps no history between instructions, so an instruction that is run again is judged only on its own bytes and the current task-switched bit.

Top module: `pshift_exc_prio`

## Requirements
- R1: During and directly after reset, excCode is 00 and excValid is 0.
- R2: The result appears one clock after inValid: excValid is 1 exactly in the cycle after an unflushed strobe, and excCode is 00 whenever excValid is 0.
- R3: For opByte 71h or 72h with inEscape=1 and mod field (modrmModReg[4:3]) equal to 11b, reg field (modrmModReg[2:0]) values 010b, 100b and 110b are legal; any other reg value gives code 01 (invalid opcode).
- R4: For opByte 73h with inEscape=1 and mod 11b, only reg values 010b and 110b are legal; the rest give code 01.
- R5: For any of 71h, 72h or 73h with inEscape=1, a mod field other than 11b gives code 01, whatever the reg field is.
- R6: An illegal encoding gives code 01 even when taskSwitched is 1; code 10 is never reported for it.
- R7: A legal encoding gives code 10 (device-not-available) when taskSwitched is 1 and code 00 when it is 0.
- R8: When inEscape is 0, or opByte is not 71h, 72h or 73h, the code is 00 regardless of taskSwitched and ModR/M.
- R9: flush sampled high makes the next cycle show excCode 00 and excValid 0, clearing a held exception and discarding a strobe in the same cycle.
- R10: Re-presenting an illegal encoding after taskSwitched is cleared gives code 01 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction bytes are valid this cycle |
| inEscape | input | 1 | First opcode byte is the 0Fh escape |
| opByte | input | 8 | Second opcode byte |
| modrmModReg | input | 5 | ModR/M bits 7:3 (mod in [4:3], reg in [2:0]) |
| taskSwitched | input | 1 | Task-switched control bit |
| flush | input | 1 | Discard the output result |
| excCode | output | 2 | 00 none, 01 invalid opcode, 10 device-not-available |
| excValid | output | 1 | Registered copy of an unflushed strobe |

## Verification
All eight reg values under each of the three shift opcodes are swept with mod 11b and both task-switched states, which separates the two legal-set shapes and shows that the invalid code outranks device-not-available. Non-register mod values and foreign opcodes or a missing escape show that only the shift group is screened. Flush is tried against a held exception and against a strobe in the same cycle, and an illegal encoding is repeated after the task-switched bit clears. A seeded random stream biased towards the shift opcodes then mixes every field against a bench model.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  localparam int BYTE_W  = 8;
  localparam int MOD_W   = 2;
  localparam int REG_W   = 3;
  localparam int FIELD_W = MOD_W + REG_W;
  localparam int NUM_GRP = 3;
  localparam logic [BYTE_W-1:0] GRP_BASE = 8'h71;
  localparam logic [MOD_W-1:0] MOD_REGISTER = 2'b11;

  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_UD   = 2'b01,
    EXC_DNA  = 2'b10
  } exc_e;

  typedef struct packed {
    logic capture;
    logic clear;
    logic raiseUd;
    logic raiseDna;
  } ctrl_strobe_t;

  // Opcode byte of shift group member g.
  function automatic logic [BYTE_W-1:0] grpOpcode(input int g);
    return GRP_BASE + BYTE_W'(g);
  endfunction

  // Legal reg-field values of group member g, one bit per reg value.
  function automatic logic [(1<<REG_W)-1:0] grpRegMask(input int g);
    logic [(1<<REG_W)-1:0] m;
    m = '0;
    m[2] = 1'b1;
    m[6] = 1'b1;
    if (g < NUM_GRP - 1) m[4] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pshift_ctrl.sv
module pshift_ctrl
  import pshift_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inEscape,
  input  logic [BYTE_W-1:0]    opByte,
  input  logic [FIELD_W-1:0]   modrmModReg,
  input  logic                 taskSwitched,
  input  logic                 flush,
  output ctrl_strobe_t         strb
);
  localparam int REG_VALS = 1 << REG_W;

  logic [MOD_W-1:0]   modField;
  logic [REG_W-1:0]   regField;
  logic [NUM_GRP-1:0] grpHit;
  logic [NUM_GRP-1:0] grpRegOk;
  logic isShift;
  logic encOk;

  assign modField = modrmModReg[FIELD_W-1:REG_W];
  assign regField = modrmModReg[REG_W-1:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    localparam logic [BYTE_W-1:0]   OPC  = grpOpcode(g);
    localparam logic [REG_VALS-1:0] MASK = grpRegMask(g);
    assign grpHit[g]   = (opByte == OPC);
    assign grpRegOk[g] = MASK[regField];
  end

  assign isShift = inEscape && (|grpHit);
  assign encOk   = (modField == MOD_REGISTER) && (|(grpHit & grpRegOk));

  always_comb begin
    strb          = '0;
    strb.capture  = inValid;
    strb.clear    = flush;
    strb.raiseUd  = inValid && isShift && !encOk;
    strb.raiseDna = inValid && isShift && encOk && taskSwitched;
  end

  // R6: an illegal form never requests device-not-available.
  assert_ud_over_dna_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inEscape && (|grpHit) && modField != MOD_REGISTER) |-> (strb.raiseUd && !strb.raiseDna));

  // R8: foreign instructions raise nothing.
  assert_foreign_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!inEscape || !(|grpHit)) |-> !(strb.raiseUd || strb.raiseDna));
endmodule

// File: rtl/pshift_dp.sv
module pshift_dp
  import pshift_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strb,
  output exc_e         excReg,
  output logic         validReg
);
  always_ff @(posedge clk) begin
    if (!rstN || strb.clear || !strb.capture) begin
      excReg   <= EXC_NONE;
      validReg <= 1'b0;
    end else begin
      validReg <= 1'b1;
      if (strb.raiseUd)       excReg <= EXC_UD;
      else if (strb.raiseDna) excReg <= EXC_DNA;
      else                    excReg <= EXC_NONE;
    end
  end

  // R9: a flush empties the output register.
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (excReg == EXC_NONE && !validReg));

  // R2: an unflushed strobe shows up one cycle later.
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.clear) |=> validReg);

  // R2: no code without a valid result.
  assert_idle_none_R2: assert property (@(posedge clk) disable iff (!rstN)
    !validReg |-> (excReg == EXC_NONE));

  // R6: invalid-opcode request wins the register.
  assert_ud_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.clear && strb.raiseUd) |=> (excReg == EXC_UD));

  // R7: only defined codes are held.
  assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(excReg));
endmodule

// File: rtl/pshift_exc_prio.sv
module pshift_exc_prio
  import pshift_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inEscape,
  input  logic [7:0] opByte,
  input  logic [4:0] modrmModReg,
  input  logic       taskSwitched,
  input  logic       flush,
  output logic [1:0] excCode,
  output logic       excValid
);
  ctrl_strobe_t strb;
  exc_e         excReg;

  pshift_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEscape(inEscape),
    .opByte(opByte), .modrmModReg(modrmModReg), .taskSwitched(taskSwitched),
    .flush(flush), .strb(strb)
  );

  pshift_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .excReg(excReg), .validReg(excValid)
  );

  assign excCode = excReg;

  // R1: reset leaves the output empty.
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rstN |=> (excCode == 2'b00 && !excValid));
endmodule

// File: tb/pshift_exc_prio_test.sv
module pshift_exc_prio_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inEscape = 1'b0, taskSwitched = 1'b0, flush = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic [4:0] modrmModReg = 5'd0;
  logic [1:0] excCode;
  logic excValid;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pshift_exc_prio uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEscape(inEscape),
    .opByte(opByte), .modrmModReg(modrmModReg), .taskSwitched(taskSwitched),
    .flush(flush), .excCode(excCode), .excValid(excValid)
  );

  function automatic logic [1:0] model(input logic esc, input logic [7:0] op,
                                       input logic [4:0] mr, input logic ts);
    logic legal;
    if (!esc || !(op == 8'h71 || op == 8'h72 || op == 8'h73)) return 2'b00;
    if (mr[4:3] != 2'b11) return 2'b01;
    if (op == 8'h73) legal = (mr[2:0] == 3'd2 || mr[2:0] == 3'd6);
    else legal = (mr[2:0] == 3'd2 || mr[2:0] == 3'd4 || mr[2:0] == 3'd6);
    if (!legal) return 2'b01;
    return ts ? 2'b10 : 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] expCode, input logic expValid);
    checks++;
    if (excCode !== expCode || excValid !== expValid) begin
      fails++;
      $display("FAIL %s: code=%b valid=%b expected code=%b valid=%b",
               req, excCode, excValid, expCode, expValid);
    end
  endtask

  // Drive at negedge, result visible after next posedge, sample at following negedge.
  task automatic issue(input string req, input logic esc, input logic [7:0] op,
                       input logic [4:0] mr, input logic ts, input logic fl);
    inValid = 1'b1; inEscape = esc; opByte = op; modrmModReg = mr;
    taskSwitched = ts; flush = fl;
    @(negedge clk);
    inValid = 1'b0; flush = 1'b0;
    if (fl) check(req, 2'b00, 1'b0);
    else    check(req, model(esc, op, mr, ts), 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: code=%b valid=%b expected completion", excCode, excValid);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 during reset", 2'b00, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 2'b00, 1'b0);

    // R3 R4 R6 R7: full reg sweep with mod 11b, both task-switched states.
    for (int o = 0; o < 3; o++)
      for (int r = 0; r < 8; r++)
        for (int t = 0; t < 2; t++)
          issue(o == 2 ? "R4 sweep" : "R3 R6 R7 sweep", 1'b1, 8'h71 + 8'(o),
                {2'b11, 3'(r)}, 1'(t), 1'b0);

    // R5: non-register mod values, including legal reg values.
    for (int o = 0; o < 3; o++)
      for (int m = 0; m < 3; m++)
        issue("R5 memory form", 1'b1, 8'h71 + 8'(o), {2'(m), 3'd2}, 1'b1, 1'b0);

    // R8: foreign opcodes and missing escape.
    issue("R8 other opcode", 1'b1, 8'h74, 5'b11001, 1'b1, 1'b0);
    issue("R8 other opcode", 1'b1, 8'h70, 5'b00000, 1'b1, 1'b0);
    issue("R8 no escape", 1'b0, 8'h71, 5'b00001, 1'b1, 1'b0);

    // R2: idle cycle after a result.
    @(negedge clk);
    check("R2 idle", 2'b00, 1'b0);

    // R9: clear held exception, and discard concurrent strobe.
    issue("R9 setup", 1'b1, 8'h73, 5'b11100, 1'b0, 1'b0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R9 clear held", 2'b00, 1'b0);
    issue("R9 concurrent", 1'b1, 8'h72, 5'b11000, 1'b1, 1'b1);

    // R10: illegal form, then repeat with task-switched cleared.
    issue("R10 first", 1'b1, 8'h71, 5'b11011, 1'b1, 1'b0);
    issue("R10 repeat", 1'b1, 8'h71, 5'b11011, 1'b0, 1'b0);

    // Random mix, R3 R4 R5 R6 R7 R8.
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom_range(0, 4));
      op = (sel < 3) ? 8'h71 + 8'(sel) : 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R2 random idle", 2'b00, 1'b0);
      end
      issue("R3 R4 R5 R6 R7 R8 random", ($urandom_range(0, 4) != 0), op,
            5'($urandom), 1'($urandom), 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule